// File: doc/BRIEF.md
# Byte Pattern and Bit Manipulation Unit

This execution unit handles the 32-bit operations that work on fields rather than on arithmetic: finding the first equal byte lane between two words, equality and inequality tests, counting leading zeros, reordering bytes and halfwords, sign-extending a narrow value, and one-position right shifts that pass a bit through the carry flag. Each accepted operation takes two operands, a four-bit operation code and the current carry. One clock later the unit presents a 32-bit result and the carry value that follows.

A pipeline stage raises `in_valid` for one cycle for each operation it issues. `out_valid` rises on the next cycle, together with the result and the carry. In cycles with no accepted operation, the output registers keep their values. Unary operations read only `opnd_a`.

Top module: `bytebit_unit`

## Requirements
- R1: Byte-find (op 0) compares the four byte lanes of `opnd_a` and `opnd_b`. It returns 1 if bits 31:24 match. Otherwise it returns 2 if bits 23:16 match, 3 if bits 15:8 match, and 4 if bits 7:0 match. It returns 0 when no lane matches.
- R2: Equality (op 1) returns 1 when the operands are equal and 0 otherwise. Inequality (op 2) returns the inverse.
- R3: Leading-zero count (op 3) returns the number of zero bits above the highest set bit of `opnd_a`. An all-zero operand gives 32.
- R4: Byte swap (op 4) reverses the order of the four bytes of `opnd_a`. Halfword swap (op 5) exchanges its bits 31:16 and 15:0.
- R5: Byte sign-extend (op 6) copies bit 7 into bits 31:8. Halfword sign-extend (op 7) copies bit 15 into bits 31:16.
- R6: The one-bit right shifts move `opnd_a` down one place. The new bit 31 is the old bit 31 for the arithmetic shift (op 8), 0 for the logical shift (op 9) and `carry_in` for the through-carry shift (op 10).
- R7: For ops 8, 9 and 10, `carry_out` becomes bit 0 of `opnd_a`.
- R8: For every op other than 8, 9 and 10, `carry_out` becomes `carry_in`.
- R9: Unused op codes 11 to 15 return a result of 0.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result and carry of that operation appear in the same cycle.
- R11: While `in_valid` is low, `result` and `carry_out` keep their previous values.
- R12: During reset, `out_valid`, `result` and `carry_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operation presented this cycle |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand (the only one read by unary ops) |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Registered updated carry |

## Verification
The byte-find priority is hardest to expose. A correct-looking design can still return the wrong lane when more than one lane matches, or when only the least significant lane matches. The stimulus therefore uses operand pairs in which the top lane and a lower lane match together, and pairs in which each single lane is the only match. Carry handling is covered by running non-shift operations with `carry_in` set, and by following a through-carry shift with a different incoming carry.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

    typedef enum logic [3:0] {
        OP_BFIND  = 4'd0,
        OP_EQ     = 4'd1,
        OP_NE     = 4'd2,
        OP_CLZ    = 4'd3,
        OP_SWAPB  = 4'd4,
        OP_SWAPH  = 4'd5,
        OP_SEXT8  = 4'd6,
        OP_SEXT16 = 4'd7,
        OP_SRA    = 4'd8,
        OP_SRL    = 4'd9,
        OP_SRC    = 4'd10
    } op_e;

    localparam int OP_W = 4;

endpackage

// File: rtl/bbu_lane_cmp.sv
// Per-lane byte equality, the first-match index and whole-word equality.
module bbu_lane_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]               a,
    input  logic [DATA_W-1:0]               b,
    output logic [$clog2(DATA_W/8+1)-1:0]   find_idx,
    output logic                            word_eq
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES + 1);

    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = (a[8*g +: 8] == b[8*g +: 8]);
    end

    // The loop runs from the low lane up, so a higher lane overrides a lower one.
    always_comb begin
        find_idx = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_hit[i]) begin
                find_idx = IDX_W'(LANES - i);
            end
        end
    end

    assign word_eq = &lane_hit;

endmodule

// File: rtl/bbu_clz.sv
// Leading-zero counter. An all-zero input gives DATA_W.
module bbu_clz #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]             a,
    output logic [$clog2(DATA_W+1)-1:0]   count
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    always_comb begin
        count = CNT_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (a[i]) begin
                count = CNT_W'(DATA_W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/bbu_perm.sv
// Byte and halfword reordering, and narrow-field sign extension.
module bbu_perm #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] swap_b,
    output logic [DATA_W-1:0] swap_h,
    output logic [DATA_W-1:0] sext_b,
    output logic [DATA_W-1:0] sext_h
);
    localparam int LANES = DATA_W / 8;
    localparam int HALF  = DATA_W / 2;

    for (genvar g = 0; g < LANES; g++) begin : g_rev
        assign swap_b[8*g +: 8] = a[8*(LANES-1-g) +: 8];
    end

    assign swap_h = {a[HALF-1:0], a[DATA_W-1:HALF]};
    assign sext_b = {{(DATA_W-8){a[7]}}, a[7:0]};
    assign sext_h = {{(DATA_W-16){a[15]}}, a[15:0]};

endmodule

// File: rtl/bbu_shr1.sv
// One-place right shifts. The bit shifted out goes to carry.
module bbu_shr1 #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    output logic [DATA_W-1:0] sh_arith,
    output logic [DATA_W-1:0] sh_logic,
    output logic [DATA_W-1:0] sh_carry,
    output logic              out_bit
);
    assign sh_arith = {a[DATA_W-1], a[DATA_W-1:1]};
    assign sh_logic = {1'b0,        a[DATA_W-1:1]};
    assign sh_carry = {cin,         a[DATA_W-1:1]};
    assign out_bit  = a[0];

endmodule

// File: rtl/bytebit_unit.sv
module bytebit_unit
    import bbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES + 1);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              cy;
    } stage_t;

    stage_t st_d, st_q;

    logic [IDX_W-1:0]  find_idx;
    logic              word_eq;
    logic [CNT_W-1:0]  lz_cnt;
    logic [DATA_W-1:0] swap_b, swap_h, sext_b, sext_h;
    logic [DATA_W-1:0] sh_arith, sh_logic, sh_carry;
    logic              sh_out;

    bbu_lane_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a        (opnd_a),
        .b        (opnd_b),
        .find_idx (find_idx),
        .word_eq  (word_eq)
    );

    bbu_clz #(.DATA_W(DATA_W)) u_clz (
        .a     (opnd_a),
        .count (lz_cnt)
    );

    bbu_perm #(.DATA_W(DATA_W)) u_perm (
        .a      (opnd_a),
        .swap_b (swap_b),
        .swap_h (swap_h),
        .sext_b (sext_b),
        .sext_h (sext_h)
    );

    bbu_shr1 #(.DATA_W(DATA_W)) u_shr (
        .a        (opnd_a),
        .cin      (carry_in),
        .sh_arith (sh_arith),
        .sh_logic (sh_logic),
        .sh_carry (sh_carry),
        .out_bit  (sh_out)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.cy = carry_in;
            unique case (op)
                OP_BFIND:  st_d.res = DATA_W'(find_idx);
                OP_EQ:     st_d.res = DATA_W'(word_eq);
                OP_NE:     st_d.res = DATA_W'(!word_eq);
                OP_CLZ:    st_d.res = DATA_W'(lz_cnt);
                OP_SWAPB:  st_d.res = swap_b;
                OP_SWAPH:  st_d.res = swap_h;
                OP_SEXT8:  st_d.res = sext_b;
                OP_SEXT16: st_d.res = sext_h;
                OP_SRA: begin
                    st_d.res = sh_arith;
                    st_d.cy  = sh_out;
                end
                OP_SRL: begin
                    st_d.res = sh_logic;
                    st_d.cy  = sh_out;
                end
                OP_SRC: begin
                    st_d.res = sh_carry;
                    st_d.cy  = sh_out;
                end
                default:   st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign carry_out = st_q.cy;

endmodule

// File: rtl/bbu_checker.sv
module bbu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              carry_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              carry_out
);
    logic is_shift;
    assign is_shift = (op == 4'd8) || (op == 4'd9) || (op == 4'd10);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(carry_out)));

    // R7
    shift_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_shift) |=> (carry_out == $past(opnd_a[0])));

    // R8
    keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_shift) |=> (carry_out == $past(carry_in)));

    // R2
    eq_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd1 || op == 4'd2)) |=>
            ($countones(result) <= 1));

    // R3
    clz_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd3) |=> (result <= DATA_W'(DATA_W)));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd11) |=> (result == '0));

endmodule

bind bytebit_unit bbu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .out_valid (out_valid),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sim_bytebit_unit.sv
`timescale 1ns/1ps
module sim_bytebit_unit;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        cin;
        logic [31:0] res;
        logic        cy;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  32'h12345678, 32'h12AABBCC, 1'b0, 32'd1,        1'b0}, // R1 top lane
        '{4'd0,  32'h12345678, 32'hFF34EE00, 1'b1, 32'd2,        1'b1}, // R1 lane 2, R8
        '{4'd0,  32'h12345678, 32'h00005678, 1'b0, 32'd3,        1'b0}, // R1 two lanes
        '{4'd0,  32'h12345678, 32'hAABBCC78, 1'b0, 32'd4,        1'b0}, // R1 low lane only
        '{4'd0,  32'h12345678, 32'h87654321, 1'b1, 32'd0,        1'b1}, // R1 none
        '{4'd0,  32'h12345678, 32'h12345678, 1'b0, 32'd1,        1'b0}, // R1 all lanes
        '{4'd1,  32'hDEADBEEF, 32'hDEADBEEF, 1'b1, 32'd1,        1'b1}, // R2
        '{4'd1,  32'hDEADBEEF, 32'hDEADBEEE, 1'b0, 32'd0,        1'b0}, // R2
        '{4'd2,  32'hDEADBEEF, 32'hDEADBEEE, 1'b0, 32'd1,        1'b0}, // R2
        '{4'd2,  32'h00000000, 32'h00000000, 1'b1, 32'd0,        1'b1}, // R2
        '{4'd3,  32'h00010000, 32'h0,        1'b0, 32'd15,       1'b0}, // R3
        '{4'd3,  32'h80000000, 32'h0,        1'b0, 32'd0,        1'b0}, // R3
        '{4'd3,  32'h00000001, 32'h0,        1'b1, 32'd31,       1'b1}, // R3
        '{4'd3,  32'h00000000, 32'h0,        1'b0, 32'd32,       1'b0}, // R3 zero
        '{4'd4,  32'h11223344, 32'h0,        1'b1, 32'h44332211, 1'b1}, // R4
        '{4'd5,  32'h11223344, 32'h0,        1'b0, 32'h33441122, 1'b0}, // R4
        '{4'd6,  32'h12345680, 32'h0,        1'b0, 32'hFFFFFF80, 1'b0}, // R5
        '{4'd6,  32'hFFFFFF7F, 32'h0,        1'b1, 32'h0000007F, 1'b1}, // R5
        '{4'd7,  32'h00008001, 32'h0,        1'b0, 32'hFFFF8001, 1'b0}, // R5
        '{4'd7,  32'hABCD1234, 32'h0,        1'b0, 32'h00001234, 1'b0}, // R5
        '{4'd8,  32'h80000003, 32'h0,        1'b0, 32'hC0000001, 1'b1}, // R6 R7
        '{4'd8,  32'h7FFFFFFE, 32'h0,        1'b1, 32'h3FFFFFFF, 1'b0}, // R6 R7
        '{4'd9,  32'h80000003, 32'h0,        1'b0, 32'h40000001, 1'b1}, // R6 R7
        '{4'd10, 32'h80000002, 32'h0,        1'b1, 32'hC0000001, 1'b0}, // R6 R7
        '{4'd10, 32'h00000004, 32'h0,        1'b0, 32'h00000002, 1'b0}, // R6 R7
        '{4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b1}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bytebit_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .out_valid (out_valid),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'd0:                 return "R1";
            4'd1, 4'd2:           return "R2";
            4'd3:                 return "R3";
            4'd4, 4'd5:           return "R4";
            4'd6, 4'd7:           return "R5";
            4'd8, 4'd9, 4'd10:    return "R6";
            default:              return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic c);
        @(negedge clk);
        in_valid = 1'b1;
        op       = o;
        opnd_a   = a;
        opnd_b   = b;
        carry_in = c;
    endtask

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12", {31'b0, out_valid}, 32'd0);
        check("R12", result, 32'd0);
        check("R12", {31'b0, carry_out}, 32'd0);
        rst_n = 1'b1;

        // Vector table, one operation per cycle
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cin);
            @(negedge clk);
            check(req_of(VECS[i].op), result, VECS[i].res);
            // R7 for shifts, R8 otherwise
            check((VECS[i].op >= 4'd8 && VECS[i].op <= 4'd10) ? "R7" : "R8",
                  {31'b0, carry_out}, {31'b0, VECS[i].cy});
            check("R10", {31'b0, out_valid}, 32'd1);
            in_valid = 1'b0;
        end

        // R10: out_valid falls in the idle cycle after the last issue
        @(negedge clk);
        check("R10", {31'b0, out_valid}, 32'd0);

        // R11: idle input with new operands leaves outputs unchanged
        issue(4'd4, 32'hA1B2C3D4, 32'h0, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        op       = 4'd3;
        opnd_a   = 32'h0;
        carry_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11", result, 32'hD4C3B2A1);
        check("R11", {31'b0, carry_out}, 32'd1);
        check("R10", {31'b0, out_valid}, 32'd0);

        // R10: back-to-back issues, each result one cycle later
        issue(4'd5, 32'hCAFEF00D, 32'h0, 1'b0);
        @(negedge clk);
        check("R10", result, 32'hF00DCAFE);
        in_valid = 1'b1;
        op       = 4'd10;
        opnd_a   = 32'h00000001;
        carry_in = 1'b1;
        @(negedge clk);
        check("R6", result, 32'h80000000);
        check("R7", {31'b0, carry_out}, 32'd1);
        check("R10", {31'b0, out_valid}, 32'd1);
        in_valid = 1'b0;

        // R12: reset clears the outputs again
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R12", result, 32'd0);
        check("R12", {31'b0, carry_out}, 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule